// File: doc/BRIEF.md
# Status Register and Write Guard for a Serial Memory

This block holds the status byte of a serial nonvolatile memory and decides, on every cycle, whether a write may land. The command engine that shifts the serial bus feeds it one-cycle strobes: arm writes, disarm writes, load the status byte, and end of a memory write command. It also feeds the level of the write-protect pin and the byte address that a memory write is aimed at. The block answers with two grant lines, one for the memory byte at that address and one for a status load, and it supplies the byte that a status read returns.

The status byte has a lock-enable bit, three spare bits, a two-bit protected-region code, the write-enable flag and a bit that always reads zero. Every bit except the write-enable flag stands in for nonvolatile storage. It keeps its value through a soft reset and is cleared only by the power-on reset. The write-enable flag is volatile. It drops on every reset, on a disarm, and when any status load or memory write command ends, so each write command has to be armed again. A denied byte is dropped by the command engine, which still steps its address. The grant lines are combinational, so every byte of a burst is judged against the flag as it stood before the burst.

Top module: `stat_wprot`

## Requirements
- R1: While the power-on reset is applied and after it is released, the status byte reads 0x00 and both grant lines are low.
- R2: An arm strobe sets the write-enable flag, seen as status bit 1 one cycle later. A disarm strobe clears it. When both strobes arrive in the same cycle, the flag ends up clear.
- R3: A status load strobe copies data bit 7 to the lock-enable bit, bits 6..4 to the spare bits and bits 3..2 to the region code, provided the status grant is high in that cycle. The flag is cleared after the strobe whether or not the load was granted.
- R4: The end-of-write strobe clears the write-enable flag. Before it arrives, the memory grant stays high for an unprotected address.
- R5: With the write-enable flag clear, both grant lines are low for every address.
- R6: The region code in status bits 3..2 decides which memory addresses are protected. 00 protects none. 01 protects the top quarter, where the two address MSBs are 11. 10 protects the top half, where the address MSB is 1. 11 protects all addresses. A protected address never gets a memory grant.
- R7: With the flag set, the status grant is low only when the lock-enable bit is 1 and the write-protect pin is low. When the lock-enable bit is 0, the pin has no effect.
- R8: A status load made while the status grant is low leaves status bits 7..2 unchanged.
- R9: A soft reset clears the write-enable flag and keeps status bits 7..2. A status load in the same cycle as a soft reset is ignored.
- R10: Status bit 0 always reads 0, and data bits 1..0 of a status load are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears every bit |
| soft_rst | input | 1 | Synchronous soft reset; clears only the write-enable flag |
| wel_set | input | 1 | Arm strobe from the command engine |
| wel_clr | input | 1 | Disarm strobe |
| sr_wr | input | 1 | Status load strobe, qualified by the status grant |
| sr_wdata | input | 8 | Byte carried with the status load strobe |
| wr_done | input | 1 | End of a memory write command (select released) |
| wp_n | input | 1 | Write-protect pin level, low means protect |
| mem_addr | input | ADDR_W | Byte address of the pending memory write |
| mem_wr_ok | output | 1 | Grant for writing the byte at mem_addr |
| sr_wr_ok | output | 1 | Grant for a status load |
| sr_rdata | output | 8 | Status byte returned by a status read |

## Verification
The two grant lines depend combinationally on the address, the pin and the stored state, so they are due in the same cycle that their inputs settle. Every strobe takes effect at the next rising edge, so a change to the status byte or to the grants that follows from it is visible one cycle after the strobe. The bench drives inputs just after a rising edge and pushes the expected byte and grants into a queue. A monitor compares them at the following falling edge, which is one full edge after any strobe and about half a cycle after any address or pin change.

// File: rtl/stat_wprot_pkg.sv
package stat_wprot_pkg;

   // persistent part of the status byte (survives soft reset)
   typedef struct packed {
      logic       lock_en;   // status bit 7
      logic [2:0] spare;     // status bits 6..4
      logic [1:0] region;    // status bits 3..2
   } nv_bits_t;

   localparam int unsigned SR_W = 8;

   typedef enum logic [1:0] {
      REG_NONE    = 2'b00,
      REG_QUARTER = 2'b01,
      REG_HALF    = 2'b10,
      REG_ALL     = 2'b11
   } region_e;

   function automatic logic [SR_W-1:0] pack_status(nv_bits_t nv, logic wel);
      return {nv.lock_en, nv.spare, nv.region, wel, 1'b0};
   endfunction

   function automatic nv_bits_t unpack_load(logic [SR_W-1:0] d);
      nv_bits_t n;
      n.lock_en = d[7];
      n.spare   = d[6:4];
      n.region  = d[3:2];
      return n;
   endfunction

endpackage

// File: rtl/stat_wprot_regs.sv
module stat_wprot_regs
   import stat_wprot_pkg::*;
#(
   parameter bit KEEP_SPARE = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             soft_rst,
   input  logic             wel_set,
   input  logic             wel_clr,
   input  logic             sr_wr,
   input  logic [SR_W-1:0]  sr_wdata,
   input  logic             wr_done,
   input  logic             sr_ok,
   output nv_bits_t         nv_q,
   output logic             wel_q
);

   nv_bits_t load_v;
   logic     take_load;

   assign take_load = sr_wr && sr_ok && !soft_rst;

   always_comb begin
      load_v = unpack_load(sr_wdata);
   end

   // lock and region bits
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         nv_q.lock_en <= 1'b0;
         nv_q.region  <= 2'b00;
      end else if (take_load) begin
         nv_q.lock_en <= load_v.lock_en;
         nv_q.region  <= load_v.region;
      end
   end

   // spare bits: stored or tied off
   generate
      if (KEEP_SPARE) begin : g_spare_kept
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)         nv_q.spare <= 3'b000;
            else if (take_load) nv_q.spare <= load_v.spare;
         end
      end else begin : g_spare_zero
         assign nv_q.spare = 3'b000;
      end
   endgenerate

   // volatile write-enable flag: every clear source wins over arm
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                     wel_q <= 1'b0;
      else if (soft_rst || wel_clr || sr_wr || wr_done) wel_q <= 1'b0;
      else if (wel_set)                               wel_q <= 1'b1;
   end

   p_arm_r2: assert property (@(posedge clk) disable iff (!por_n)
      (wel_set && !wel_clr && !sr_wr && !wr_done && !soft_rst) |=> wel_q);
   p_disarm_r2: assert property (@(posedge clk) disable iff (!por_n)
      wel_clr |=> !wel_q);
   p_load_drops_wel_r3: assert property (@(posedge clk) disable iff (!por_n)
      sr_wr |=> !wel_q);
   p_done_drops_wel_r4: assert property (@(posedge clk) disable iff (!por_n)
      wr_done |=> !wel_q);
   p_denied_keeps_r8: assert property (@(posedge clk) disable iff (!por_n)
      (sr_wr && !sr_ok) |=> $stable(nv_q));
   p_soft_keeps_r9: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> ($stable(nv_q) && !wel_q));

endmodule

// File: rtl/stat_wprot_decode.sv
module stat_wprot_decode
   import stat_wprot_pkg::*;
#(
   parameter int unsigned ADDR_W = 14
) (
   input  logic              clk,
   input  logic              por_n,
   input  nv_bits_t          nv,
   input  logic              wel,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              mem_ok,
   output logic              sr_ok
);

   localparam int unsigned TOP = ADDR_W - 1;

   logic [1:0] top2;
   logic       in_region;
   region_e    code;

   assign top2 = addr[TOP -: 2];
   assign code = region_e'(nv.region);

   always_comb begin
      unique case (code)
         REG_NONE:    in_region = 1'b0;
         REG_QUARTER: in_region = (top2 == 2'b11);
         REG_HALF:    in_region = top2[1];
         default:     in_region = 1'b1;
      endcase
   end

   assign mem_ok = wel && !in_region;
   assign sr_ok  = wel && !(nv.lock_en && !wp_n);

   p_no_flag_r5: assert property (@(posedge clk) disable iff (!por_n)
      !wel |-> (!mem_ok && !sr_ok));
   p_all_locked_r6: assert property (@(posedge clk) disable iff (!por_n)
      (nv.region == 2'b11) |-> !mem_ok);
   p_half_locked_r6: assert property (@(posedge clk) disable iff (!por_n)
      (nv.region[1] && addr[TOP]) |-> !mem_ok);
   p_pin_lock_r7: assert property (@(posedge clk) disable iff (!por_n)
      (nv.lock_en && !wp_n) |-> !sr_ok);
   p_pin_free_r7: assert property (@(posedge clk) disable iff (!por_n)
      (wel && !nv.lock_en) |-> sr_ok);

endmodule

// File: rtl/stat_wprot.sv
module stat_wprot
   import stat_wprot_pkg::*;
#(
   parameter int unsigned ADDR_W     = 14,
   parameter bit          KEEP_SPARE = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_rst,
   input  logic              wel_set,
   input  logic              wel_clr,
   input  logic              sr_wr,
   input  logic [7:0]        sr_wdata,
   input  logic              wr_done,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wr_ok,
   output logic              sr_wr_ok,
   output logic [7:0]        sr_rdata
);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("stat_wprot: ADDR_W must be at least 2");
      end
   endgenerate

   nv_bits_t nv;
   logic     wel;

   stat_wprot_regs #(.KEEP_SPARE(KEEP_SPARE)) u_regs (
      .clk      (clk),
      .por_n    (por_n),
      .soft_rst (soft_rst),
      .wel_set  (wel_set),
      .wel_clr  (wel_clr),
      .sr_wr    (sr_wr),
      .sr_wdata (sr_wdata),
      .wr_done  (wr_done),
      .sr_ok    (sr_wr_ok),
      .nv_q     (nv),
      .wel_q    (wel)
   );

   stat_wprot_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk    (clk),
      .por_n  (por_n),
      .nv     (nv),
      .wel    (wel),
      .wp_n   (wp_n),
      .addr   (mem_addr),
      .mem_ok (mem_wr_ok),
      .sr_ok  (sr_wr_ok)
   );

   assign sr_rdata = pack_status(nv, wel);

   p_bit0_low_r10: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sr_wr) |=> !sr_rdata[0]);
   p_por_clear_r1: assert property (@(posedge clk)
      !por_n |-> (sr_rdata == 8'h00 && !mem_wr_ok && !sr_wr_ok));

endmodule

// File: tb/sim_stat_wprot.sv
module sim_stat_wprot;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        wel_set = 1'b0;
   logic        wel_clr = 1'b0;
   logic        sr_wr = 1'b0;
   logic [7:0]  sr_wdata = 8'h00;
   logic        wr_done = 1'b0;
   logic        wp_n = 1'b1;
   logic [13:0] mem_addr = 14'h0;
   logic        mem_wr_ok, sr_wr_ok;
   logic [7:0]  sr_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      string      tag;
      logic [7:0] sr;
      logic       mok;
      logic       sok;
   } exp_t;

   exp_t q[$];

   always #5 clk = ~clk;

   stat_wprot #(.ADDR_W(14), .KEEP_SPARE(1'b1)) u0 (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
      .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr),
      .sr_wdata(sr_wdata), .wr_done(wr_done), .wp_n(wp_n),
      .mem_addr(mem_addr), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok),
      .sr_rdata(sr_rdata)
   );

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (sr_rdata !== e.sr || mem_wr_ok !== e.mok || sr_wr_ok !== e.sok) begin
            bad++;
            $display("FAIL %s: got sr=%02h mok=%0b sok=%0b exp sr=%02h mok=%0b sok=%0b",
                     e.tag, sr_rdata, mem_wr_ok, sr_wr_ok, e.sr, e.mok, e.sok);
         end
      end
   end

   task automatic expect_at(string tag, logic [13:0] a, logic [7:0] s, logic m, logic k);
      exp_t e;
      mem_addr = a;
      e.tag = tag; e.sr = s; e.mok = m; e.sok = k;
      q.push_back(e);
      @(negedge clk);
      #1;
   endtask

   task automatic arm();
      @(posedge clk); #1 wel_set = 1'b1;
      @(posedge clk); #1 wel_set = 1'b0;
   endtask

   task automatic disarm();
      @(posedge clk); #1 wel_clr = 1'b1;
      @(posedge clk); #1 wel_clr = 1'b0;
   endtask

   task automatic load(logic [7:0] d);
      @(posedge clk); #1 sr_wr = 1'b1; sr_wdata = d;
      @(posedge clk); #1 sr_wr = 1'b0;
   endtask

   task automatic end_write();
      @(posedge clk); #1 wr_done = 1'b1;
      @(posedge clk); #1 wr_done = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: held in power-on reset
      expect_at("R1 in reset", 14'h0000, 8'h00, 1'b0, 1'b0);
      por_n = 1'b1;
      @(posedge clk); #1;
      expect_at("R1 after reset", 14'h0000, 8'h00, 1'b0, 1'b0);

      // R2: arm, then disarm, then both at once
      arm();
      expect_at("R2 arm", 14'h3FFF, 8'h02, 1'b1, 1'b1);
      disarm();
      expect_at("R2 disarm / R5 deny", 14'h3FFF, 8'h00, 1'b0, 1'b0);
      @(posedge clk); #1 wel_set = 1'b1; wel_clr = 1'b1;
      @(posedge clk); #1 wel_set = 1'b0; wel_clr = 1'b0;
      expect_at("R2 arm+disarm clear wins", 14'h0000, 8'h00, 1'b0, 1'b0);

      // R3: granted load sets lock, spare, region=11; flag cleared; R10 low bits dropped
      arm();
      load(8'hFF);
      expect_at("R3 load FF / R10", 14'h0000, 8'hFC, 1'b0, 1'b0);
      // R6: region 11 protects all; R7 pin high -> status grant
      arm();
      expect_at("R6 all protected", 14'h0000, 8'hFE, 1'b0, 1'b1);
      // R7: lock + pin low -> status denied
      wp_n = 1'b0;
      expect_at("R7 pin lock", 14'h0000, 8'hFE, 1'b0, 1'b0);
      // R8: denied load keeps bits, still drops flag
      load(8'h00);
      expect_at("R8 denied load", 14'h0000, 8'hFC, 1'b0, 1'b0);

      // R9: soft reset drops flag, keeps persistent bits, ignores load
      arm();
      wp_n = 1'b1;
      @(posedge clk); #1 soft_rst = 1'b1; sr_wr = 1'b1; sr_wdata = 8'h00;
      @(posedge clk); #1 soft_rst = 1'b0; sr_wr = 1'b0;
      expect_at("R9 soft reset", 14'h0000, 8'hFC, 1'b0, 1'b0);

      // R3/R10: region 01, lock 1, data bits 1..0 ignored
      arm();
      load(8'h87);
      expect_at("R10 low bits dropped", 14'h0000, 8'h84, 1'b0, 1'b0);
      // R6: quarter boundary
      arm();
      expect_at("R6 quarter below", 14'h2FFF, 8'h86, 1'b1, 1'b1);
      expect_at("R6 quarter above", 14'h3000, 8'h86, 1'b0, 1'b1);

      // R4: burst granted until write end, then flag gone
      expect_at("R4 burst byte", 14'h0100, 8'h86, 1'b1, 1'b1);
      expect_at("R4 burst next", 14'h0101, 8'h86, 1'b1, 1'b1);
      end_write();
      expect_at("R4 after end", 14'h0102, 8'h84, 1'b0, 1'b0);

      // R6 half region, R7 lock off lets pin low through
      arm();
      load(8'h08);
      expect_at("R3 load 08", 14'h0000, 8'h08, 1'b0, 1'b0);
      wp_n = 1'b0;
      arm();
      expect_at("R7 no lock pin low", 14'h1FFF, 8'h0A, 1'b1, 1'b1);
      expect_at("R6 half above", 14'h2000, 8'h0A, 1'b0, 1'b1);
      // R6: region 00 protects nothing
      load(8'h70);
      arm();
      expect_at("R6 none top addr", 14'h3FFF, 8'h72, 1'b1, 1'b1);

      // R1: power-on reset clears persistent bits
      @(posedge clk); #1 por_n = 1'b0;
      @(posedge clk); #1 por_n = 1'b1;
      expect_at("R1 por clears", 14'h3FFF, 8'h00, 1'b0, 1'b0);

      @(posedge clk); #1;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule